// File: doc/BRIEF.md
# Fail-first vector condition-bit logic sequencer

This block runs a vector loop of single-bit condition-register logic operations over element indices 0 to VL-1, one element per clock. For each element it fetches two source bits from a 32-bit condition file, combines them with one of eight boolean operations, and writes the result into a target bit of the same file. The three bit selectors each pick a field and a bit inside that field, and the field part advances with the element index.

The target bit is also the early-exit test bit. After each write the result is compared with an expected polarity. A mismatch stops the loop at that element and shortens the vector length. Later horizontal work then runs with the shorter length, which is held on `vl_o`. An inclusive flag chooses whether the failing element counts in the new length.

A start pulse while idle loads the condition file from `cr_i` and the length from `vl_i`. All other control inputs must stay stable until `done_o` pulses.

Top module: `ffcr_seq`

## Requirements
- R1: A selector value s addresses condition bit s. Its field is s[4:2] and its bit-in-field is s[1:0]. For element i, each of the three selectors uses field (s[4:2]+i) mod 8 and keeps the same bit-in-field.
- R2: op_i encodes the result r from source bits a (picked by ba_i) and b (picked by bb_i): 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 equivalence (XNOR), 6 a AND NOT b, 7 a OR NOT b. The result r is written to the bit picked by bc_i.
- R3: Elements are processed in index order, one per cycle, starting in the cycle after start is accepted. Each element reads the file as updated by earlier elements. done_o pulses for one cycle after the last processed element.
- R4: An element's test passes when r equals 1 with inv_i=0, or when r equals 0 with inv_i=1. Otherwise the test fails.
- R5: When an element's test fails, the loop ends at that element. No later element writes the file.
- R6: On a failure with vli_i=0, vl_o becomes the failing element's index.
- R7: On a failure with vli_i=1, vl_o becomes the failing element's index plus one.
- R8: The failing element's result bit is written to the file in both modes.
- R9: If every element passes, vl_o keeps the loaded length, and done_o follows element VL-1.
- R10: A start with vl_i=0 raises done_o in the next cycle and leaves the loaded file unchanged.
- R11: While idle, vl_o and cr_o hold their values until the next start. A start pulse during a run is ignored.
- R12: After reset, cr_o is 0, vl_o is 0 and done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a loop (taken only when idle) |
| vl_i | input | 7 | Vector length loaded at start |
| op_i | input | 3 | Boolean operation code |
| ba_i | input | 5 | First source bit selector |
| bb_i | input | 5 | Second source bit selector |
| bc_i | input | 5 | Target and test bit selector |
| inv_i | input | 1 | Test expects 0 when set, 1 when clear |
| vli_i | input | 1 | Count the failing element in the new length |
| cr_i | input | 32 | Condition file contents loaded at start |
| cr_o | output | 32 | Current condition file |
| vl_o | output | 7 | Current (possibly truncated) vector length |
| done_o | output | 1 | One-cycle pulse at loop end |

## Verification
Random condition files, selectors, operations, polarities and lengths up to 40 mix passing and failing elements. They also let later elements read bits written by earlier ones, which separates a correct sequential model from one that reads a snapshot. Directed runs cover the corner cases. An all-passing loop longer than eight elements shows field wraparound and an unchanged length. A failure on the last element with the inclusive flag set separates the two length rules where they would otherwise give the same result. A zero length, inverted polarity and a start pulse during a run are also tried, and the completion latency shows how many elements actually ran.

// File: rtl/ffcr_pkg.sv
package ffcr_pkg;
  localparam int FLDW = 3;
  localparam int BITW = 2;
  localparam int SELW = FLDW + BITW;
  localparam int CRW  = 1 << SELW;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_NAND = 3'd3,
    OP_NOR  = 3'd4,
    OP_EQV  = 3'd5,
    OP_ANDC = 3'd6,
    OP_ORC  = 3'd7
  } crop_e;

  // Advance the field part of a selector, keeping the bit-in-field part.
  function automatic logic [SELW-1:0] step_sel(input logic [SELW-1:0] s,
                                               input logic [FLDW-1:0] off);
    logic [FLDW-1:0] fld;
    fld = s[SELW-1:BITW] + off;
    return {fld, s[BITW-1:0]};
  endfunction

  function automatic logic crlogic(input crop_e op, input logic a, input logic b);
    logic r;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_NAND: r = ~(a & b);
      OP_NOR:  r = ~(a | b);
      OP_EQV:  r = ~(a ^ b);
      OP_ANDC: r = a & ~b;
      default: r = a | ~b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ffcr_selmap.sv
module ffcr_selmap
  import ffcr_pkg::*;
(
  input  logic [SELW-1:0] ba_i,
  input  logic [SELW-1:0] bb_i,
  input  logic [SELW-1:0] bc_i,
  input  logic [FLDW-1:0] off_i,
  output logic [SELW-1:0] a_sel_o,
  output logic [SELW-1:0] b_sel_o,
  output logic [SELW-1:0] t_sel_o
);
  assign a_sel_o = step_sel(ba_i, off_i);
  assign b_sel_o = step_sel(bb_i, off_i);
  assign t_sel_o = step_sel(bc_i, off_i);

  // R1
  always_comb begin
    bitpos_keep_chk: assert (t_sel_o[BITW-1:0] == bc_i[BITW-1:0]);
  end
endmodule

// File: rtl/ffcr_logic.sv
module ffcr_logic
  import ffcr_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_i,
  output logic       res_o,
  output logic       fail_o
);
  assign res_o  = crlogic(crop_e'(op_i), a_i, b_i);
  // Test passes when the result differs from the invert flag.
  assign fail_o = (res_o == inv_i);
endmodule

// File: rtl/ffcr_crfile.sv
module ffcr_crfile
  import ffcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [CRW-1:0]  load_data_i,
  input  logic            we_i,
  input  logic [SELW-1:0] wsel_i,
  input  logic            wbit_i,
  output logic [CRW-1:0]  cr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cr_o <= '0;
    else if (load_i) cr_o <= load_data_i;
    else if (we_i) cr_o[wsel_i] <= wbit_i;
  end

  // R11
  cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !we_i) |=> $stable(cr_o));

  // R8
  cr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && we_i) |=> ($countones(cr_o ^ $past(cr_o)) <= 1));
endmodule

// File: rtl/ffcr_ctrl.sv
module ffcr_ctrl #(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           vli_i,
  input  logic           fail_i,
  output logic           accept_o,
  output logic           busy_o,
  output logic [VLW-1:0] idx_o,
  output logic [VLW-1:0] vl_o,
  output logic           done_o
);
  logic [VLW-1:0] idx_nxt;
  logic           fail_ev;
  logic           last_ev;

  assign accept_o = start_i && !busy_o;
  assign idx_nxt  = idx_o + {{(VLW-1){1'b0}}, 1'b1};
  assign fail_ev  = busy_o && fail_i;
  assign last_ev  = busy_o && !fail_i && (idx_nxt == vl_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      vl_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) begin
        vl_o   <= vl_i;
        idx_o  <= '0;
        busy_o <= (vl_i != '0);
        done_o <= (vl_i == '0);
      end else if (fail_ev) begin
        vl_o   <= vli_i ? idx_nxt : idx_o;
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else if (last_ev) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else if (busy_o) begin
        idx_o <= idx_nxt;
      end
    end
  end

  // R5
  fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_ev |=> (!busy_o && done_o));

  // R6
  vl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_ev && !vli_i) |=> (vl_o == $past(idx_o)));

  // R7
  vl_incl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_ev && vli_i) |=> (vl_o == $past(idx_o) + 1'b1));

  // R9
  vl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fail_i) |=> $stable(vl_o));

  // R10
  zero_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && vl_i == '0) |=> (done_o && !busy_o));

  // R11
  vl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(vl_o));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fail_ev && !last_ev) |=> (busy_o && idx_o == $past(idx_o) + 1'b1));
endmodule

// File: rtl/ffcr_seq.sv
module ffcr_seq
  import ffcr_pkg::*;
#(
  parameter int VLW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [2:0]      op_i,
  input  logic [SELW-1:0] ba_i,
  input  logic [SELW-1:0] bb_i,
  input  logic [SELW-1:0] bc_i,
  input  logic            inv_i,
  input  logic            vli_i,
  input  logic [CRW-1:0]  cr_i,
  output logic [CRW-1:0]  cr_o,
  output logic [VLW-1:0]  vl_o,
  output logic            done_o
);
  logic            accept;
  logic            busy;
  logic [VLW-1:0]  idx;
  logic [SELW-1:0] a_sel, b_sel, t_sel;
  logic            res_bit, fail;

  ffcr_selmap u_selmap (
    .ba_i    (ba_i),
    .bb_i    (bb_i),
    .bc_i    (bc_i),
    .off_i   (idx[FLDW-1:0]),
    .a_sel_o (a_sel),
    .b_sel_o (b_sel),
    .t_sel_o (t_sel)
  );

  ffcr_logic u_logic (
    .op_i   (op_i),
    .a_i    (cr_o[a_sel]),
    .b_i    (cr_o[b_sel]),
    .inv_i  (inv_i),
    .res_o  (res_bit),
    .fail_o (fail)
  );

  ffcr_crfile u_crfile (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .load_data_i (cr_i),
    .we_i        (busy),
    .wsel_i      (t_sel),
    .wbit_i      (res_bit),
    .cr_o        (cr_o)
  );

  ffcr_ctrl #(.VLW(VLW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .vli_i    (vli_i),
    .fail_i   (fail),
    .accept_o (accept),
    .busy_o   (busy),
    .idx_o    (idx),
    .vl_o     (vl_o),
    .done_o   (done_o)
  );

  // R12
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (cr_o == '0 && vl_o == '0 && !done_o));
endmodule

// File: tb/ffcr_seq_tb.sv
module ffcr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  vl_i = '0;
  logic [2:0]  op_i = '0;
  logic [4:0]  ba_i = '0, bb_i = '0, bc_i = '0;
  logic        inv_i = 1'b0, vli_i = 1'b0;
  logic [31:0] cr_i = '0;
  logic [31:0] cr_o;
  logic [6:0]  vl_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  ffcr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .op_i(op_i),
    .ba_i(ba_i), .bb_i(bb_i), .bc_i(bc_i), .inv_i(inv_i), .vli_i(vli_i),
    .cr_i(cr_i), .cr_o(cr_o), .vl_o(vl_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit bool_op(input int op, input bit a, input bit b);
    case (op)
      0: return a && b;
      1: return a || b;
      2: return a != b;
      3: return !(a && b);
      4: return !(a || b);
      5: return a == b;
      6: return a && !b;
      default: return a || !b;
    endcase
  endfunction

  function automatic int bitpos(input int s, input int i);
    return (((s / 4) + i) % 8) * 4 + (s % 4);
  endfunction

  // Sequential reference: returns final file, length, elements run, fail flag.
  task automatic model(input bit [31:0] c0, input int vl, input int op,
                       input int ba, input int bb, input int bc,
                       input bit inv, input bit vli,
                       output bit [31:0] ecr, output int evl,
                       output int eproc, output bit efail);
    bit r;
    ecr = c0; evl = vl; eproc = 0; efail = 0;
    for (int i = 0; i < vl; i++) begin
      r = bool_op(op, ecr[bitpos(ba, i)], ecr[bitpos(bb, i)]);
      ecr[bitpos(bc, i)] = r;
      eproc++;
      if (r == inv) begin
        efail = 1;
        evl = vli ? i + 1 : i;
        break;
      end
    end
  endtask

  // One loop. restart_mid pulses start again during the run with a different file.
  task automatic run(input string tag, input bit [31:0] c0, input int vl,
                     input int op, input int ba, input int bb, input int bc,
                     input bit inv, input bit vli, input bit restart_mid);
    bit [31:0] ecr; int evl, eproc, n; bit efail;
    string vtag;
    model(c0, vl, op, ba, bb, bc, inv, vli, ecr, evl, eproc, efail);
    @(negedge clk);
    cr_i = c0; vl_i = 7'(vl); op_i = 3'(op);
    ba_i = 5'(ba); bb_i = 5'(bb); bc_i = 5'(bc);
    inv_i = inv; vli_i = vli; start_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      start_i = 1'b0;
      n++;
      if (restart_mid && n == 2 && !done_o) begin
        start_i = 1'b1;
        cr_i = ~c0;
      end
    end while (!done_o && n < 200);
    start_i = 1'b0;
    if (vl == 0) vtag = "R10";
    else if (efail && vli) vtag = "R7";
    else if (efail) vtag = "R6";
    else vtag = "R9";
    chk({tag, " R3 latency"}, n, (vl == 0) ? 1 : eproc + 1);
    chk({tag, efail ? " R8 R5 cr" : " R2 cr"}, cr_o, ecr);
    chk({tag, " ", vtag, " vl"}, vl_o, evl);
    @(negedge clk);
    chk({tag, " R3 done pulse"}, done_o, 0);
    chk({tag, " R11 vl held"}, vl_o, evl);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 3);
    // R12 reset state
    chk("R12 cr", cr_o, 0);
    chk("R12 vl", vl_o, 0);
    chk("R12 done", done_o, 0);
    rst_n = 1'b1;

    // R10 zero length: no writes
    run("R10", 32'hA5A5_1234, 0, 1, 0, 1, 2, 0, 0, 0);
    // R9 R1 all pass over 20 elements, fields wrap past 8
    run("R9 R1", 32'hFFFF_FFFF, 20, 0, 3, 6, 9, 0, 0, 0);
    // R1 wrap with bit position: OR of set bit in field 7 onward
    run("R1", 32'h0000_0001, 12, 1, 0, 0, 30, 0, 0, 0);
    // R4 inverted polarity: NOR of zeros gives 1, fails at element 0
    run("R4 R6", 32'h0000_0000, 5, 4, 1, 2, 3, 1, 0, 0);
    run("R4 R7", 32'h0000_0000, 5, 4, 1, 2, 3, 1, 1, 0);
    // R5 R6 mid-run failure: AND over set fields, field 3 cleared
    run("R5 R6", 32'hFFFF_0FFF, 8, 0, 0, 1, 2, 0, 0, 0);
    run("R5 R7", 32'hFFFF_0FFF, 8, 0, 0, 1, 2, 0, 1, 0);
    // R7 failure on last element with inclusive: length unchanged
    run("R7 last", 32'hFFFF_0FFF, 4, 0, 0, 1, 2, 0, 1, 0);
    // R11 start during run ignored
    run("R11 restart", 32'hFFFF_FFFF, 10, 0, 0, 4, 8, 0, 0, 1);
    // R2 every operation, random files
    for (int op = 0; op < 8; op++)
      run("R2 op", $urandom, 6, op, $urandom % 32, $urandom % 32, $urandom % 32,
          1'($urandom % 2), 1'($urandom % 2), 0);
    // random mix
    for (int k = 0; k < 60; k++)
      run("rand", $urandom, $urandom % 41, $urandom % 8, $urandom % 32,
          $urandom % 32, $urandom % 32, 1'($urandom % 2), 1'($urandom % 2), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule